// File: doc/BRIEF.md
# Seven-Level Stacked-Carrier PWM Gate Pattern Generator

This block drives the six switches of a single-phase seven-level bridge. The bridge is built from a full bridge plus two bidirectional switches that tap the DC bus at one third and two thirds of its voltage. On every clock the block reads a reference sample, given as an unsigned magnitude and a separate sign bit. It compares that sample with one shared digital triangle carrier and picks one of seven output levels. It then registers the six gate signals for that level.

The reference magnitude spans three stacked bands. Each band is one carrier peak high. The lowest band modulates between zero and one third of the bus. The middle band modulates between one third and two thirds. The top band modulates between two thirds and the full bus. The band boundaries are set by the same programmable carrier peak, so the modulation index is the reference peak-to-peak value divided by three carrier peak-to-peak values. The sign bit selects the polarity. The slow leg of the bridge (S2, S4) follows only the sign, and the fast switches (S1, S3, S5, S6) carry the carrier-rate pulses.

Top module: `sevlvl_pwm`

## Requirements
- R1: While reset is asserted, every gate output is 0 and the carrier is held at 0.
- R2: The carrier counts up by one per clock from 0 to the active peak, then down by one per clock back to 0, which gives a period of twice the peak in clocks.
- R3: A new carrier peak setting takes effect only on a clock where the carrier is at 0, and a setting of 0 is treated as 1.
- R4: Let P be the active peak. The band index b is 2 when the magnitude is at least 2P, 1 when it is at least P, and 0 otherwise. The level magnitude is b+1 when (magnitude − b·P) is greater than the carrier, and b otherwise.
- R5: A magnitude above 3P selects the full-bus level on every clock.
- R6: Gate bit i drives switch S(i+1). Positive levels +3, +2 and +1 give the gate values 6'b001001 (S1,S4), 6'b011000 (S5,S4) and 6'b101000 (S6,S4).
- R7: Negative levels −1, −2 and −3 give 6'b010010 (S5,S2), 6'b100010 (S6,S2) and 6'b000110 (S2,S3).
- R8: Level 0 gives 6'b001100 (S3,S4) when the sign bit is 0, and 6'b000011 (S1,S2) when the sign bit is 1.
- R9: Out of reset, S2 equals the sign bit of the previous clock and S4 is its inverse, so the slow leg changes only when the sign changes.
- R10: All six gates come from one register. They show the level computed from the inputs and the carrier value present one clock earlier.
- R11: Out of reset, exactly two gates are on. S1 and S3 are never both on, and S5 and S6 are never both on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| peakSet | input | CW | Requested carrier peak (0 acts as 1) |
| refMag | input | CW+2 | Reference magnitude, nominally 0 to 3× peak |
| refNeg | input | 1 | Reference sign, 1 means negative half |
| gateOut | output | 6 | Gate signals; bit i drives S(i+1) |

## Verification
The assertions assume that reset is held across at least one clock edge. They also assume that the sign bit and magnitude are steady around each rising edge. The stimulus drives every input on the falling edge. The peak-hold and step-by-one carrier properties assume nothing about the peak setting itself, so the bench changes the peak at arbitrary carrier phases, including to 0. The bench also sweeps the magnitude past 3P to exercise saturation, and it flips the sign both mid-band and at zero.

// File: rtl/sevlvl_pkg.sv
package sevlvl_pkg;

  localparam int NUM_SW   = 6;
  localparam int NUM_BAND = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic inMid;    // magnitude reached one peak
    logic inTop;    // magnitude reached two peaks
    logic negHalf;  // reference sign
  } ctlStrobe_t;

  // gate patterns, bit i = switch i+1
  localparam logic [NUM_SW-1:0] GATE_P3   = 6'b001001;
  localparam logic [NUM_SW-1:0] GATE_P2   = 6'b011000;
  localparam logic [NUM_SW-1:0] GATE_P1   = 6'b101000;
  localparam logic [NUM_SW-1:0] GATE_Z_P  = 6'b001100;
  localparam logic [NUM_SW-1:0] GATE_Z_N  = 6'b000011;
  localparam logic [NUM_SW-1:0] GATE_N1   = 6'b010010;
  localparam logic [NUM_SW-1:0] GATE_N2   = 6'b100010;
  localparam logic [NUM_SW-1:0] GATE_N3   = 6'b000110;

endpackage

// File: rtl/sevlvl_ctrl.sv
module sevlvl_ctrl
  import sevlvl_pkg::*;
#(
  parameter int CW = 8,
  parameter int RW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] peakSet,
  input  logic [RW-1:0] refMag,
  input  logic          refNeg,
  output logic [CW-1:0] carrier,
  output logic [CW-1:0] peak,
  output ctlStrobe_t    stb
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          goingUp;
  logic [CW-1:0] effCfg;
  logic [CW-1:0] peakNow;
  logic [RW-1:0] peakW;
  logic [RW-1:0] twoPeak;

  assign effCfg  = (peakSet == '0) ? ONE : peakSet;
  assign peakNow = (carrier == '0) ? effCfg : peak;

  // triangle carrier, peak reloaded only at the bottom
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carrier <= '0;
      goingUp <= 1'b1;
      peak    <= ONE;
    end else begin
      peak <= peakNow;
      if (carrier == '0) begin
        carrier <= ONE;
        goingUp <= 1'b1;
      end else if (goingUp && (carrier >= peakNow)) begin
        carrier <= carrier - ONE;
        goingUp <= 1'b0;
      end else if (goingUp) begin
        carrier <= carrier + ONE;
      end else begin
        carrier <= carrier - ONE;
      end
    end
  end

  // band selection strobes
  assign peakW   = RW'(peak);
  assign twoPeak = peakW << 1;

  always_comb begin
    stb.inMid   = (refMag >= peakW);
    stb.inTop   = (refMag >= twoPeak);
    stb.negHalf = refNeg;
  end

endmodule

// File: rtl/sevlvl_dp.sv
module sevlvl_dp
  import sevlvl_pkg::*;
#(
  parameter int CW = 8,
  parameter int RW = CW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RW-1:0]     refMag,
  input  logic [CW-1:0]     carrier,
  input  logic [CW-1:0]     peak,
  input  ctlStrobe_t        stb,
  output logic [NUM_SW-1:0] gateOut
);

  logic [NUM_BAND-1:0] bandHit;
  logic [RW-1:0]       carW;
  logic [1:0]          bandIdx;
  logic [1:0]          levMag;
  logic                upHit;
  logic [NUM_SW-1:0]   gateNext;

  assign carW = RW'(carrier);

  // one comparator per stacked reference band
  for (genvar k = 0; k < NUM_BAND; k++) begin : g_band
    logic [RW-1:0] base;
    logic [RW-1:0] sub;
    assign base       = RW'(k) * RW'(peak);
    assign sub        = refMag - base;
    assign bandHit[k] = (sub > carW);
  end

  always_comb begin
    if (stb.inTop) begin
      bandIdx = 2'd2;
      upHit   = bandHit[2];
    end else if (stb.inMid) begin
      bandIdx = 2'd1;
      upHit   = bandHit[1];
    end else begin
      bandIdx = 2'd0;
      upHit   = bandHit[0];
    end
    levMag = bandIdx + {1'b0, upHit};
  end

  // level to switch encoding
  always_comb begin
    unique case ({stb.negHalf, levMag})
      3'b011:  gateNext = GATE_P3;
      3'b010:  gateNext = GATE_P2;
      3'b001:  gateNext = GATE_P1;
      3'b000:  gateNext = GATE_Z_P;
      3'b100:  gateNext = GATE_Z_N;
      3'b101:  gateNext = GATE_N1;
      3'b110:  gateNext = GATE_N2;
      default: gateNext = GATE_N3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gateOut <= '0;
    else        gateOut <= gateNext;
  end

endmodule

// File: rtl/sevlvl_pwm.sv
module sevlvl_pwm
  import sevlvl_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] peakSet,
  input  logic [CW+1:0] refMag,
  input  logic          refNeg,
  output logic [5:0]    gateOut
);

  localparam int RW = CW + 2;

  logic [CW-1:0] carrierVal;
  logic [CW-1:0] peakVal;
  ctlStrobe_t    stb;

  sevlvl_ctrl #(.CW(CW), .RW(RW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .peakSet (peakSet),
    .refMag  (refMag),
    .refNeg  (refNeg),
    .carrier (carrierVal),
    .peak    (peakVal),
    .stb     (stb)
  );

  sevlvl_dp #(.CW(CW), .RW(RW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .refMag  (refMag),
    .carrier (carrierVal),
    .peak    (peakVal),
    .stb     (stb),
    .gateOut (gateOut)
  );

endmodule

// File: rtl/sevlvl_pwm_chk.sv
module sevlvl_pwm_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          refNeg,
  input logic [5:0]    gateOut,
  input logic [CW-1:0] carrier,
  input logic [CW-1:0] peak
);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R11
  gate_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ($countones(gateOut) == 2));

  // R11
  leg_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (!(gateOut[0] && gateOut[2]) && !(gateOut[4] && gateOut[5])));

  // R9
  slow_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((gateOut[1] == $past(refNeg)) && (gateOut[3] == !$past(refNeg))));

  // R2
  carrier_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carrier <= peak);

  // R2
  carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((int'(carrier) == int'($past(carrier)) + 1) ||
                 (int'(carrier) == int'($past(carrier)) - 1)));

  // R3
  peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(carrier) != '0) |-> $stable(peak));

  // R3
  peak_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak != '0);

endmodule

bind sevlvl_pwm sevlvl_pwm_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .refNeg  (refNeg),
  .gateOut (gateOut),
  .carrier (carrierVal),
  .peak    (peakVal)
);

// File: tb/sevlvl_pwm_bench.sv
module sevlvl_pwm_bench;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] peakSet = 8'd5;
  logic [CW+1:0] refMag = '0;
  logic          refNeg = 1'b0;
  logic [5:0]    gateOut;

  int checks = 0;
  int errors = 0;
  bit checking = 0;

  // behavioural model state
  int mCar = 0, mPeak = 1, mUp = 1, expLev = 0;
  logic [5:0] expGate = '0;
  logic       expNeg = 1'b0;

  sevlvl_pwm #(.CW(CW)) u_sevlvl_pwm (
    .clk(clk), .rst_n(rst_n), .peakSet(peakSet),
    .refMag(refMag), .refNeg(refNeg), .gateOut(gateOut)
  );

  always #10 clk = ~clk;

  function automatic logic [5:0] patFor(int lev, logic neg);
    case (lev)
      3:  return 6'b001001;   // S1 S4
      2:  return 6'b011000;   // S5 S4
      1:  return 6'b101000;   // S6 S4
      -1: return 6'b010010;   // S5 S2
      -2: return 6'b100010;   // S6 S2
      -3: return 6'b000110;   // S2 S3
      default: return neg ? 6'b000011 : 6'b001100;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mCar = 0; mPeak = 1; mUp = 1; expGate = '0; expLev = 0;
    end else begin
      int mag, b, sub, lev, eff, pn;
      mag = int'(refMag);
      b = (mag >= 2*mPeak) ? 2 : (mag >= mPeak) ? 1 : 0;
      sub = mag - b*mPeak;
      lev = b + ((sub > mCar) ? 1 : 0);
      if (refNeg) lev = -lev;
      expLev = lev;
      expNeg = refNeg;
      expGate = patFor(lev, refNeg);
      eff = (peakSet == 0) ? 1 : int'(peakSet);
      pn = (mCar == 0) ? eff : mPeak;
      mPeak = pn;
      if (mCar == 0) begin mCar = 1; mUp = 1; end
      else if (mUp != 0 && mCar >= pn) begin mCar = mCar - 1; mUp = 0; end
      else if (mUp != 0) mCar = mCar + 1;
      else mCar = mCar - 1;
    end
  end

  task automatic check(bit ok, string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (checking) begin
      string tag;
      tag = (expLev > 0) ? "R6" : (expLev < 0) ? "R7" : "R8";
      check(gateOut == expGate, {tag, " R2 R3 R4 R5 R10"}, gateOut, expGate);
      // R9 slow leg follows sign
      check(gateOut[1] == expNeg && gateOut[3] == !expNeg, "R9", gateOut, expGate);
      // R11 two switches, no leg short
      check($countones(gateOut) == 2 && !(gateOut[0] && gateOut[2]) &&
            !(gateOut[4] && gateOut[5]), "R11", gateOut, expGate);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    // R1 reset state
    check(gateOut == 6'b0, "R1", gateOut, 6'b0);
    check(u_sevlvl_pwm.gateOut == 6'b0, "R1", gateOut, 6'b0);
    rst_n = 1'b1;
    step(1);
    checking = 1;

    // sweep magnitude through all bands and past saturation, both signs
    for (int cyc = 0; cyc < 4; cyc++) begin
      refNeg = cyc[0];
      for (int m = 0; m <= 17; m++) begin refMag = 10'(m); step(7); end
      for (int m = 17; m >= 0; m--) begin refMag = 10'(m); step(5); end
    end

    // R3 peak changes at arbitrary phases, including 0
    for (int p = 0; p < 6; p++) begin
      peakSet = 8'((p * 3) % 9);
      for (int m = 0; m < 30; m++) begin
        refMag = 10'((m * 7) % 30);
        refNeg = m[2];
        step(3);
      end
    end

    // R2 period: one S6 pulse per 2*peak clocks at magnitude 1
    peakSet = 8'd4; refMag = 10'd1; refNeg = 1'b0;
    step(20);
    begin
      int pulses = 0;
      for (int i = 0; i < 80; i++) begin
        step(1);
        if (gateOut == 6'b101000) pulses++;
      end
      check(pulses == 10, "R2", 6'(pulses), 6'd10);
    end

    // R5 saturation: full level every clock
    refMag = 10'h3FF;
    step(2);
    begin
      int full = 0;
      for (int i = 0; i < 40; i++) begin
        step(1);
        if (gateOut == 6'b001001) full++;
      end
      check(full == 40, "R5", 6'(full), 6'd40);
    end

    // R8 zero by polarity, R9 flip at zero
    refMag = 10'd0; refNeg = 1'b1; step(3);
    check(gateOut == 6'b000011, "R8", gateOut, 6'b000011);
    refNeg = 1'b0; step(1);
    check(gateOut == 6'b001100, "R8", gateOut, 6'b001100);

    checking = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule